// File: doc/BRIEF.md
# Parallel Port Bit Latch and Pin Driver

This block is the digital side of one parallel port of a small microcontroller. Each pin has a storage bit that the CPU loads from its internal data bus with a write strobe. Two read strobes give the CPU two different views: one returns the stored bits, and the other returns the levels actually present on the pins. The pins are modelled as three signals per bit: a drive enable, a drive value and a sampled input level. In general-purpose use a stored 0 pulls the pin low. A stored 1 releases the pin, so it can serve as an input.

When the core runs an external-memory cycle it raises a control input. The port then hands every driver to the memory address or address/data lines, in push-pull mode. A parameter selects between two flavours. The open-drain low-byte flavour carries the multiplexed low address and data byte, and it forces its stored bits to all ones while the memory control input is high. The pulled-up high-address flavour carries the upper address byte of a program fetch, or the middle and top bytes of a 24-bit data address, and it leaves its stored bits untouched. Pin levels pass through a two-flop synchronizer before they reach the bus. Stored bits are returned in the same cycle.

Top module: `mcu_port`

## Requirements
- R1: After reset every stored bit is 1, so no pin is driven (pad_oe all 0).
- R2: A write strobe loads bus_wdata into the stored bits at the next clock edge. Without a write strobe, and with no external-memory forcing, the stored bits hold their value.
- R3: While rd_latch_stb is high, bus_rdata shows the stored bits in the same cycle. This takes priority over rd_pin_stb.
- R4: While only rd_pin_stb is high, bus_rdata shows the pin levels that were present two clock edges earlier. The synchronizer resets to all ones.
- R5: With xmem_ctrl low, a stored 0 gives pad_oe=1 and pad_out=0, and a stored 1 gives pad_oe=0. pad_out is 0 whenever the pin is not driven by the memory path.
- R6: With xmem_ctrl high, every pad_oe bit is 1 and pad_out carries the selected memory byte, whatever is stored.
- R7: Open-drain flavour (FLAVOUR=0): every cycle with xmem_ctrl high sets all stored bits to 1 at the next edge. This overrides a write strobe in the same cycle.
- R8: Open-drain flavour: in memory mode pad_out is xmem_addr[7:0] when xmem_addr_phase=1, and xmem_data otherwise.
- R9: Pulled-up flavour (FLAVOUR=1): xmem_ctrl has no effect on the stored bits. A write strobe during memory mode is still taken.
- R10: Pulled-up flavour: in memory mode pad_out is xmem_addr[23:16] when xmem_data_space=1 and xmem_upper_phase=1. Otherwise it is xmem_addr[15:8], so xmem_upper_phase is ignored for program fetches (xmem_data_space=0).
- R11: For a pin whose pad_oe is 0, the sensed level is pad_in on the open-drain flavour. On the pulled-up flavour it is pad_in when pad_ext_drv is 1 for that bit and 1 when pad_ext_drv is 0. A driven pin senses pad_out.
- R12: With neither read strobe high, bus_rdata is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wdata | input | WIDTH | Internal bus write data |
| wr_latch_stb | input | 1 | Load the stored bits from bus_wdata |
| rd_latch_stb | input | 1 | Put the stored bits on bus_rdata |
| rd_pin_stb | input | 1 | Put the synchronized pin levels on bus_rdata |
| bus_rdata | output | WIDTH | Internal bus read data |
| xmem_ctrl | input | 1 | External-memory mode: the memory path takes the drivers |
| xmem_addr | input | 3*WIDTH | External memory address |
| xmem_data | input | WIDTH | Write data for the multiplexed byte |
| xmem_addr_phase | input | 1 | Open-drain flavour: 1 = address byte, 0 = data byte |
| xmem_data_space | input | 1 | Pulled-up flavour: 1 = 24-bit data access, 0 = program fetch |
| xmem_upper_phase | input | 1 | Pulled-up flavour: 1 = top address byte during a data access |
| pad_oe | output | WIDTH | Per-pin drive enable |
| pad_out | output | WIDTH | Per-pin drive value |
| pad_in | input | WIDTH | Per-pin sensed level from the pad |
| pad_ext_drv | input | WIDTH | Per-pin flag: an external source drives the pin |

## Verification
Every cycle, the assertions check several rules: the load and hold rules of the stored bits, the all-ones forcing on the open-drain flavour, and the untouched bits on the pulled-up flavour. They also check that every driver is enabled in memory mode, that a released pin is never driven in general-purpose mode, the shift through the synchronizer, the same-cycle latch readback and the quiet bus. Only the bench scenarios can show the values that end-to-end behaviour produces: the two-edge latency from a pin level to bus_rdata, the byte chosen for each memory phase on each flavour, the pull-up reading on undriven pins, and the reset state seen at the ports. The bench instantiates both flavours side by side on the same stimulus.

// File: rtl/mcu_port_pkg.sv
package mcu_port_pkg;

  typedef enum logic {
    PORT_OPEN_DRAIN = 1'b0,
    PORT_PULLED_UP  = 1'b1
  } port_flavour_e;

  // Low-byte flavour: the address byte in the address phase, otherwise the data byte.
  function automatic logic lowbyte_bit(logic addr_b, logic data_b, logic addr_phase);
    return addr_phase ? addr_b : data_b;
  endfunction

  // High-address flavour: the top byte only in the upper phase of a data access.
  function automatic logic highbyte_bit(logic mid_b, logic top_b, logic is_data, logic upper);
    return (is_data && upper) ? top_b : mid_b;
  endfunction

  // Level sensed on a pin: own driver first, then external source, then pull-up.
  function automatic logic pad_level_bit(logic oe, logic drv, logic pin_in,
                                         logic ext_drv, logic pulled);
    if (oe) return drv;
    if (pulled && !ext_drv) return 1'b1;
    return pin_in;
  endfunction

  // Next value of one stored bit: forcing beats a write, a write beats holding.
  function automatic logic next_latch_bit(logic cur, logic wr, logic wd, logic force_one);
    if (force_one) return 1'b1;
    if (wr) return wd;
    return cur;
  endfunction

endpackage

// File: rtl/mcu_port_latch.sv
module mcu_port_latch
  import mcu_port_pkg::*;
#(
  parameter int            WIDTH   = 8,
  parameter port_flavour_e FLAVOUR = PORT_OPEN_DRAIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [WIDTH-1:0] wdata,
  input  logic             xmem_ctrl,
  output logic [WIDTH-1:0] lat_q
);

  localparam bit FORCE_ON_XMEM = (FLAVOUR == PORT_OPEN_DRAIN);

  logic force_evt;   // memory mode forcing all bits high this cycle
  logic write_evt;   // write strobe that will actually land

  assign force_evt = FORCE_ON_XMEM && xmem_ctrl;
  assign write_evt = wr_stb && !force_evt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q[i] <= 1'b1;
      else        lat_q[i] <= next_latch_bit(lat_q[i], wr_stb, wdata[i], force_evt);
    end
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    write_evt |=> lat_q == $past(wdata));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !force_evt) |=> $stable(lat_q));

  if (FORCE_ON_XMEM) begin : g_force_chk
    assert_force_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
      xmem_ctrl |=> (&lat_q));
  end else begin : g_keep_chk
    assert_xmem_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xmem_ctrl && !wr_stb) |=> $stable(lat_q));
  end

endmodule

// File: rtl/mcu_port_drive.sv
module mcu_port_drive
  import mcu_port_pkg::*;
#(
  parameter int            WIDTH   = 8,
  parameter port_flavour_e FLAVOUR = PORT_OPEN_DRAIN
) (
  input  logic [WIDTH-1:0]   lat_q,
  input  logic               xmem_ctrl,
  input  logic [3*WIDTH-1:0] xmem_addr,
  input  logic [WIDTH-1:0]   xmem_data,
  input  logic               xmem_addr_phase,
  input  logic               xmem_data_space,
  input  logic               xmem_upper_phase,
  output logic [WIDTH-1:0]   pad_oe,
  output logic [WIDTH-1:0]   pad_out
);

  localparam bit LOW_BYTE = (FLAVOUR == PORT_OPEN_DRAIN);

  logic [WIDTH-1:0] mem_byte;   // byte the memory path wants on the pins

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      mem_byte[i] = LOW_BYTE
        ? lowbyte_bit(xmem_addr[i], xmem_data[i], xmem_addr_phase)
        : highbyte_bit(xmem_addr[WIDTH+i], xmem_addr[2*WIDTH+i],
                       xmem_data_space, xmem_upper_phase);
      pad_oe[i]  = xmem_ctrl || !lat_q[i];
      pad_out[i] = xmem_ctrl && mem_byte[i];
    end
  end

endmodule

// File: rtl/mcu_port_rdpath.sv
module mcu_port_rdpath
  import mcu_port_pkg::*;
#(
  parameter int            WIDTH       = 8,
  parameter int            SYNC_STAGES = 2,
  parameter port_flavour_e FLAVOUR     = PORT_OPEN_DRAIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_oe,
  input  logic [WIDTH-1:0] pad_out,
  input  logic [WIDTH-1:0] pad_in,
  input  logic [WIDTH-1:0] pad_ext_drv,
  input  logic [WIDTH-1:0] lat_q,
  input  logic             rd_latch_stb,
  input  logic             rd_pin_stb,
  output logic [WIDTH-1:0] bus_rdata
);

  localparam bit PULLED = (FLAVOUR == PORT_PULLED_UP);
  localparam int LAST   = SYNC_STAGES - 1;

  logic [WIDTH-1:0] pin_level;               // level sensed on each pin now
  logic [WIDTH-1:0] sync_q [SYNC_STAGES];    // synchronizer chain
  logic [WIDTH-1:0] pin_synced;

  for (genvar i = 0; i < WIDTH; i++) begin : g_level
    assign pin_level[i] = pad_level_bit(pad_oe[i], pad_out[i], pad_in[i],
                                        pad_ext_drv[i], PULLED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '1;
    end else begin
      sync_q[0] <= pin_level;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  assign pin_synced = sync_q[LAST];

  always_comb begin
    if (rd_latch_stb)    bus_rdata = lat_q;
    else if (rd_pin_stb) bus_rdata = pin_synced;
    else                 bus_rdata = '0;
  end

  assert_sync_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sync_q[0] == $past(pin_level));

  for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_sync_chk
    assert_sync_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> sync_q[k] == $past(sync_q[k-1]));
  end

  assert_latch_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch_stb |-> bus_rdata == lat_q);

  assert_quiet_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_latch_stb && !rd_pin_stb) |-> bus_rdata == '0);

endmodule

// File: rtl/mcu_port.sv
module mcu_port
  import mcu_port_pkg::*;
#(
  parameter int            WIDTH       = 8,
  parameter int            SYNC_STAGES = 2,
  parameter port_flavour_e FLAVOUR     = PORT_OPEN_DRAIN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH-1:0]   bus_wdata,
  input  logic               wr_latch_stb,
  input  logic               rd_latch_stb,
  input  logic               rd_pin_stb,
  output logic [WIDTH-1:0]   bus_rdata,
  input  logic               xmem_ctrl,
  input  logic [3*WIDTH-1:0] xmem_addr,
  input  logic [WIDTH-1:0]   xmem_data,
  input  logic               xmem_addr_phase,
  input  logic               xmem_data_space,
  input  logic               xmem_upper_phase,
  output logic [WIDTH-1:0]   pad_oe,
  output logic [WIDTH-1:0]   pad_out,
  input  logic [WIDTH-1:0]   pad_in,
  input  logic [WIDTH-1:0]   pad_ext_drv
);

  logic [WIDTH-1:0] lat_q;   // stored port bits, shared by drive and read paths

  mcu_port_latch #(.WIDTH(WIDTH), .FLAVOUR(FLAVOUR)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_latch_stb),
    .wdata     (bus_wdata),
    .xmem_ctrl (xmem_ctrl),
    .lat_q     (lat_q)
  );

  mcu_port_drive #(.WIDTH(WIDTH), .FLAVOUR(FLAVOUR)) u_drive (
    .lat_q            (lat_q),
    .xmem_ctrl        (xmem_ctrl),
    .xmem_addr        (xmem_addr),
    .xmem_data        (xmem_data),
    .xmem_addr_phase  (xmem_addr_phase),
    .xmem_data_space  (xmem_data_space),
    .xmem_upper_phase (xmem_upper_phase),
    .pad_oe           (pad_oe),
    .pad_out          (pad_out)
  );

  mcu_port_rdpath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .FLAVOUR(FLAVOUR)) u_rdpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .pad_oe       (pad_oe),
    .pad_out      (pad_out),
    .pad_in       (pad_in),
    .pad_ext_drv  (pad_ext_drv),
    .lat_q        (lat_q),
    .rd_latch_stb (rd_latch_stb),
    .rd_pin_stb   (rd_pin_stb),
    .bus_rdata    (bus_rdata)
  );

  assert_xmem_all_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xmem_ctrl |-> (&pad_oe));

  assert_gp_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !xmem_ctrl |-> ((pad_oe & lat_q) == '0) && (pad_out == '0));

  assert_gp_pulls_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !xmem_ctrl |-> ((pad_oe | lat_q) == '1));

endmodule

// File: tb/mcu_port_tb.sv
module mcu_port_tb_top;
  import mcu_port_pkg::*;

  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic [W-1:0] wdata;
  logic         wr, rdl, rdp, xm, ap, ds, up;
  logic [3*W-1:0] xa;
  logic [W-1:0] xd, pin, edrv;
  logic [W-1:0] od_rdata, od_oe, od_out, pu_rdata, pu_oe, pu_out;

  mcu_port #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wdata(wdata), .wr_latch_stb(wr),
    .rd_latch_stb(rdl), .rd_pin_stb(rdp), .bus_rdata(od_rdata),
    .xmem_ctrl(xm), .xmem_addr(xa), .xmem_data(xd), .xmem_addr_phase(ap),
    .xmem_data_space(ds), .xmem_upper_phase(up),
    .pad_oe(od_oe), .pad_out(od_out), .pad_in(pin), .pad_ext_drv(edrv)
  );

  mcu_port #(.WIDTH(W), .FLAVOUR(PORT_PULLED_UP)) dut_pu_i (
    .clk(clk), .rst_n(rst_n), .bus_wdata(wdata), .wr_latch_stb(wr),
    .rd_latch_stb(rdl), .rd_pin_stb(rdp), .bus_rdata(pu_rdata),
    .xmem_ctrl(xm), .xmem_addr(xa), .xmem_data(xd), .xmem_addr_phase(ap),
    .xmem_data_space(ds), .xmem_upper_phase(up),
    .pad_oe(pu_oe), .pad_out(pu_out), .pad_in(pin), .pad_ext_drv(edrv)
  );

  typedef struct {
    int           slot;
    int           which;
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  item_t sb_q[$];
  int total = 0;
  int bad = 0;
  int drv_slot = -1;
  int mon_slot = 0;
  bit started = 1'b0;
  bit finished = 1'b0;

  logic [W-1:0] m_od_lat, m_pu_lat;
  logic [W-1:0] od_hist [0:255];
  logic [W-1:0] pu_hist [0:255];

  function automatic logic [W-1:0] actual(int which);
    case (which)
      0: return od_rdata;
      1: return od_oe;
      2: return od_out;
      3: return pu_rdata;
      4: return pu_oe;
      default: return pu_out;
    endcase
  endfunction

  function automatic string port_name(int which);
    case (which)
      0: return "od.bus_rdata";
      1: return "od.pad_oe";
      2: return "od.pad_out";
      3: return "pu.bus_rdata";
      4: return "pu.pad_oe";
      default: return "pu.pad_out";
    endcase
  endfunction

  task automatic push(int which, logic [W-1:0] e, string tag);
    item_t it;
    it.slot = drv_slot; it.which = which; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // One stimulus slot: inputs change at the falling edge, the model predicts
  // this slot's outputs and then advances over the coming rising edge.
  task automatic slot(string tag, logic w_en, logic [W-1:0] w_d, logic r_l, logic r_p,
                      logic x_m, logic [3*W-1:0] x_a, logic [W-1:0] x_d,
                      logic a_p, logic d_s, logic u_p, logic [W-1:0] p_in, logic [W-1:0] e_d);
    logic [W-1:0] oe_o, out_o, oe_p, out_p, lv_o, lv_p, sel_o, sel_p;
    @(negedge clk);
    drv_slot++;
    wr = w_en; wdata = w_d; rdl = r_l; rdp = r_p; xm = x_m; xa = x_a; xd = x_d;
    ap = a_p; ds = d_s; up = u_p; pin = p_in; edrv = e_d;
    sel_o = a_p ? x_a[7:0] : x_d;
    sel_p = (d_s && u_p) ? x_a[23:16] : x_a[15:8];
    oe_o  = x_m ? 8'hFF : ~m_od_lat;
    oe_p  = x_m ? 8'hFF : ~m_pu_lat;
    out_o = x_m ? sel_o : 8'h00;
    out_p = x_m ? sel_p : 8'h00;
    lv_o  = (oe_o & out_o) | (~oe_o & p_in);
    lv_p  = (oe_p & out_p) | (~oe_p & ((e_d & p_in) | ~e_d));
    od_hist[drv_slot+2] = lv_o;
    pu_hist[drv_slot+2] = lv_p;
    push(0, r_l ? m_od_lat : (r_p ? od_hist[drv_slot] : 8'h00), tag);
    push(1, oe_o, tag);
    push(2, out_o, tag);
    push(3, r_l ? m_pu_lat : (r_p ? pu_hist[drv_slot] : 8'h00), tag);
    push(4, oe_p, tag);
    push(5, out_p, tag);
    m_od_lat = x_m ? 8'hFF : (w_en ? w_d : m_od_lat);
    m_pu_lat = w_en ? w_d : m_pu_lat;
  endtask

  // Monitor: pops this slot's expected items just before the rising edge.
  initial begin
    wait (started);
    forever begin
      @(negedge clk);
      #3;
      while (sb_q.size() > 0 && sb_q[0].slot == mon_slot) begin
        item_t it;
        logic [W-1:0] got;
        it = sb_q.pop_front();
        got = actual(it.which);
        total++;
        if (got !== it.exp) begin
          bad++;
          $display("FAIL %s %s: actual %02h expected %02h (slot %0d)",
                   it.tag, port_name(it.which), got, it.exp, it.slot);
        end
      end
      mon_slot++;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr = 0; wdata = 0; rdl = 0; rdp = 0; xm = 0; xa = 0; xd = 0;
    ap = 0; ds = 0; up = 0; pin = 8'hFF; edrv = 8'h00;
    m_od_lat = 8'hFF; m_pu_lat = 8'hFF;
    od_hist[0] = 8'hFF; od_hist[1] = 8'hFF;
    pu_hist[0] = 8'hFF; pu_hist[1] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1'b1;

    //    tag                       wr wd     rdl rdp xm xa          xd     ap ds up pin    edrv
    slot("R1 R12 reset idle",        0, 8'h00, 0, 0, 0, 24'h000000, 8'h00, 0, 0, 0, 8'hFF, 8'h00);
    slot("R1 R3 reset latch read",   0, 8'h00, 1, 0, 0, 24'h000000, 8'h00, 0, 0, 0, 8'hFF, 8'h00);
    slot("R2 write 5A",              1, 8'h5A, 0, 0, 0, 24'h000000, 8'h00, 0, 0, 0, 8'hFF, 8'h00);
    slot("R5 R3 drive from latch",   0, 8'h00, 1, 0, 0, 24'h000000, 8'h00, 0, 0, 0, 8'h3C, 8'hFF);
    slot("R2 R4 hold and pin read",  0, 8'h00, 0, 1, 0, 24'h000000, 8'h00, 0, 0, 0, 8'h3C, 8'hFF);
    slot("R4 pin sync",              0, 8'h00, 0, 1, 0, 24'h000000, 8'h00, 0, 0, 0, 8'h3C, 8'hFF);
    slot("R4 pin sync new",          0, 8'h00, 0, 1, 0, 24'h000000, 8'h00, 0, 0, 0, 8'hC3, 8'hFF);
    slot("R3 latch over pin",        0, 8'h00, 1, 1, 0, 24'h000000, 8'h00, 0, 0, 0, 8'hC3, 8'hFF);
    slot("R11 R2 release all",       1, 8'hFF, 0, 1, 0, 24'h000000, 8'h00, 0, 0, 0, 8'h00, 8'h00);
    for (int n = 0; n < 3; n++)
      slot("R11 undriven read",      0, 8'h00, 0, 1, 0, 24'h000000, 8'h00, 0, 0, 0, 8'h00, 8'h0F);
    slot("R2 write 00",              1, 8'h00, 0, 0, 0, 24'h000000, 8'h00, 0, 0, 0, 8'hFF, 8'h00);
    slot("R6 R8 R10 address phase",  0, 8'h00, 1, 0, 1, 24'h123456, 8'h9C, 1, 0, 0, 8'hFF, 8'h00);
    slot("R7 R9 latch after xmem",   0, 8'h00, 1, 0, 0, 24'h123456, 8'h9C, 0, 0, 0, 8'hFF, 8'h00);
    slot("R8 R7 R9 data phase wr",   1, 8'hA5, 0, 0, 1, 24'h123456, 8'h9C, 0, 1, 0, 8'hFF, 8'h00);
    slot("R10 R7 R9 upper phase",    0, 8'h00, 1, 0, 1, 24'h123456, 8'h9C, 0, 1, 1, 8'hFF, 8'h00);
    slot("R10 R4 fetch ignores up",  0, 8'h00, 0, 1, 1, 24'h123456, 8'h9C, 0, 0, 1, 8'hFF, 8'h00);
    slot("R4 bus readback",          0, 8'h00, 0, 1, 1, 24'hABCDEF, 8'h11, 1, 1, 0, 8'h00, 8'h00);
    slot("R4 bus readback",          0, 8'h00, 0, 1, 0, 24'h000000, 8'h00, 0, 0, 0, 8'h00, 8'h00);
    slot("R5 R12 release",           0, 8'h00, 0, 0, 0, 24'h000000, 8'h00, 0, 0, 0, 8'h00, 8'h00);
    slot("R4 R5 final pin read",     0, 8'h00, 0, 1, 0, 24'h000000, 8'h00, 0, 0, 0, 8'h00, 8'h00);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule